// File: doc/BRIEF.md
# Answer countdown and foul detector

This block runs the answer clock for the contestant who won the race to the buzzer and reports rule breaks. A host loads a starting time of up to 255 seconds. It then enables the countdown, and a one-cycle tick pulse once per second steps the remaining time down. If the clock runs out while the host keeps it enabled, the alarm sounds and the block reports the code of the latched winner as the offending group. If the host drops the enable first, the time freezes and no alarm follows.

Separately, any contestant who presses before answering is allowed commits an early foul. The alarm sounds and that contestant's group code is reported. A host clear silences the alarm, clears the foul report and reloads the starting time for the next round. An asynchronous active-low reset puts the block into the same idle state with the default time.

Group codes are binary numbers counted from one: group a is 0001, b is 0010, c is 0011 and d is 0100. 0000 means no group.

Top module: `rsp_answer_timer`

## Requirements
- R1: After the asynchronous reset rst_ni, time_o reads 60, alarm_o is 0 and foul_o is 0000.
- R2: A cycle with host_clr_i high loads init_time_i into time_o on the next edge, drops alarm_o and sets foul_o to 0000, whatever the other inputs are.
- R3: With host_clr_i low, each cycle in which tick_i and time_en_i are both high lowers a nonzero time_o by exactly one on the next edge. If either of them is low, time_o keeps its value.
- R4: When a tick takes time_o from 1 to 0 with the enable high, alarm_o rises on the same edge and foul_o shows winner_i (0001 for a, 0010 for b, 0011 for c, 0100 for d). time_o then stays at 0 on later ticks.
- R5: A press on press_i (bit 0 is a, bit 3 is d) while allow_i is low and host_clr_i is low sets alarm_o on the next edge and sets foul_o to the code of that group.
- R6: When several groups press early in the same cycle, foul_o records the group with the lowest letter.
- R7: Once foul_o is nonzero, it and alarm_o hold until the next host clear or reset, through button release, further presses and a later timeout.
- R8: Dropping time_en_i before the count reaches 0 freezes time_o, and no alarm follows while the enable stays low.
- R9: Presses while allow_i is high do not raise alarm_o or change foul_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_clr_i | input | 1 | Host round clear: reload time, silence alarm, clear foul |
| init_time_i | input | 8 | Starting answer time in seconds |
| time_en_i | input | 1 | Host countdown enable |
| allow_i | input | 1 | Answering allowed |
| press_i | input | 4 | Raw contestant buttons, bit 0 = group a |
| winner_i | input | 4 | Latched winner group code |
| tick_i | input | 1 | One-cycle pulse per second |
| time_o | output | 8 | Remaining time |
| alarm_o | output | 1 | Foul alarm |
| foul_o | output | 4 | Offending group code |

## Verification
The assertions take tick_i to be a single-cycle pulse in the clock domain. They take winner_i to carry a valid group code whenever a timeout can occur, and they take init_time_i to be stable during a clear. The stimulus drives every input at the falling edge. It raises tick_i for exactly one cycle per call, and it sets winner_i and init_time_i before the clear or countdown that uses them. Foul cases are run from a freshly cleared state, so each result comes from a single cause.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  localparam int unsigned N_GROUPS = 4;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned TIME_W   = 8;

  typedef logic [CODE_W-1:0] grp_code_t;

  // lowest set bit wins; code = index + 1, 0 = none
  function automatic grp_code_t first_code(input logic [N_GROUPS-1:0] v);
    grp_code_t c;
    c = '0;
    for (int i = N_GROUPS - 1; i >= 0; i--) begin
      if (v[i]) c = grp_code_t'(i + 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rsp_countdown.sv
module rsp_countdown #(
  parameter int unsigned TIME_W   = 8,
  parameter int unsigned INIT_DEF = 60
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [TIME_W-1:0] init_i,
  input  logic              en_i,
  input  logic              tick_i,
  output logic [TIME_W-1:0] cnt_o,
  output logic              timeout_o
);
  localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

  logic [TIME_W-1:0] cnt_q;
  logic              step;

  assign step      = en_i & tick_i & ~clr_i;
  assign timeout_o = step & (cnt_q == ONE);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= TIME_W'(INIT_DEF);
    else if (clr_i)                 cnt_q <= init_i;
    else if (step && cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == $past(init_i)); // R2
  AST_DEC_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(en_i && tick_i)) |=> $stable(cnt_q)); // R8
  AST_ZERO_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && cnt_q == '0) |=> cnt_q == '0); // R4
endmodule

// File: rtl/rsp_early_detect.sv
module rsp_early_detect
  import rsp_pkg::*;
(
  input  logic [N_GROUPS-1:0] press_i,
  input  logic                allow_i,
  input  logic                clr_i,
  output logic                hit_o,
  output grp_code_t           code_o
);
  logic [N_GROUPS-1:0] early;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_gate
    assign early[g] = press_i[g] & ~allow_i & ~clr_i;
  end

  assign hit_o  = |early;
  assign code_o = first_code(early);
endmodule

// File: rtl/rsp_foul_latch.sv
module rsp_foul_latch
  import rsp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      early_i,
  input  grp_code_t early_code_i,
  input  logic      timeout_i,
  input  grp_code_t winner_i,
  output logic      alarm_o,
  output grp_code_t foul_o
);
  logic      alarm_q;
  grp_code_t foul_q;
  logic      free;

  assign free    = (foul_q == '0);
  assign alarm_o = alarm_q;
  assign foul_o  = foul_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= 1'b0;
      foul_q  <= '0;
    end else if (clr_i) begin
      alarm_q <= 1'b0;
      foul_q  <= '0;
    end else begin
      if (early_i || timeout_i) alarm_q <= 1'b1;
      if (free) begin
        if (early_i)        foul_q <= early_code_i;   // early press has priority
        else if (timeout_i) foul_q <= winner_i;
      end
    end
  end

  AST_CLR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!alarm_q && foul_q == '0)); // R2
  AST_FOUL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && foul_q != '0) |=> $stable(foul_q)); // R7
  AST_ALARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && alarm_q) |=> alarm_q); // R7
  AST_TIMEOUT_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> alarm_q); // R4
endmodule

// File: rtl/rsp_answer_timer.sv
module rsp_answer_timer
  import rsp_pkg::*;
#(
  parameter int unsigned INIT_DEF = 60
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                host_clr_i,
  input  logic [TIME_W-1:0]   init_time_i,
  input  logic                time_en_i,
  input  logic                allow_i,
  input  logic [N_GROUPS-1:0] press_i,
  input  logic [CODE_W-1:0]   winner_i,
  input  logic                tick_i,
  output logic [TIME_W-1:0]   time_o,
  output logic                alarm_o,
  output logic [CODE_W-1:0]   foul_o
);
  logic      timeout;
  logic      early_hit;
  grp_code_t early_code;

  rsp_countdown #(.TIME_W(TIME_W), .INIT_DEF(INIT_DEF)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (host_clr_i),
    .init_i    (init_time_i),
    .en_i      (time_en_i),
    .tick_i    (tick_i),
    .cnt_o     (time_o),
    .timeout_o (timeout)
  );

  rsp_early_detect u_early (
    .press_i (press_i),
    .allow_i (allow_i),
    .clr_i   (host_clr_i),
    .hit_o   (early_hit),
    .code_o  (early_code)
  );

  rsp_foul_latch u_foul (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (host_clr_i),
    .early_i      (early_hit),
    .early_code_i (early_code),
    .timeout_i    (timeout),
    .winner_i     (winner_i),
    .alarm_o      (alarm_o),
    .foul_o       (foul_o)
  );

  AST_ALLOWED_PRESS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_clr_i && allow_i && !timeout && !alarm_o) |=> !alarm_o); // R9
endmodule

// File: tb/sim_rsp_answer_timer.sv
module sim_rsp_answer_timer;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       clr = 0;
  logic [7:0] init_t = 0;
  logic       en = 0;
  logic       allow = 0;
  logic [3:0] press = 0;
  logic [3:0] winner = 0;
  logic       tick = 0;
  logic [7:0] time_w;
  logic       alarm;
  logic [3:0] foul;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rsp_answer_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .host_clr_i(clr), .init_time_i(init_t),
    .time_en_i(en), .allow_i(allow), .press_i(press), .winner_i(winner),
    .tick_i(tick), .time_o(time_w), .alarm_o(alarm), .foul_o(foul)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1; cyc(1); tick = 0;
  endtask

  task automatic host_clear(input logic [7:0] t);
    init_t = t; en = 0; allow = 0; press = 0; clr = 1; cyc(1); clr = 0;
  endtask

  task automatic t_reset();
    cyc(1);
    chk("R1 time", time_w, 60);
    chk("R1 alarm", alarm, 0);
    chk("R1 foul", foul, 0);
  endtask

  task automatic t_load();
    host_clear(8'd25);
    chk("R2 load", time_w, 25);
  endtask

  task automatic t_count();
    host_clear(8'd10); allow = 1; en = 1;
    cyc(3);
    chk("R3 no tick", time_w, 10);
    do_tick(); chk("R3 dec", time_w, 9);
    do_tick(); chk("R3 dec2", time_w, 8);
    en = 0; do_tick(); chk("R3 tick no en", time_w, 8);
  endtask

  task automatic t_timeout();
    host_clear(8'd3); allow = 1; winner = 4'b0001; en = 1;
    do_tick(); do_tick();
    chk("R4 before zero", time_w, 1);
    chk("R4 no alarm yet", alarm, 0);
    do_tick();
    chk("R4 zero", time_w, 0);
    chk("R4 alarm", alarm, 1);
    chk("R4 foul winner a", foul, 1);
    do_tick(); chk("R4 hold zero", time_w, 0);
    press = 4'b1000; allow = 0; cyc(2); press = 0;
    chk("R7 foul kept", foul, 1);
    host_clear(8'd40);
    chk("R2 alarm clr", alarm, 0);
    chk("R2 foul clr", foul, 0);
    chk("R2 reload", time_w, 40);
  endtask

  task automatic t_freeze();
    host_clear(8'd2); allow = 1; winner = 4'b0010; en = 1;
    do_tick(); en = 0;
    for (int i = 0; i < 4; i++) do_tick();
    chk("R8 frozen", time_w, 1);
    chk("R8 no alarm", alarm, 0);
    chk("R8 no foul", foul, 0);
  endtask

  task automatic t_early();
    for (int g = 0; g < 4; g++) begin
      host_clear(8'd60);
      press = 4'(1 << g); cyc(1);
      chk("R5 alarm", alarm, 1);
      chk("R5 code", foul, g + 1);
    end
    press = 0;
  endtask

  task automatic t_multi();
    host_clear(8'd60);
    press = 4'b1100; cyc(1); press = 0;
    chk("R6 lowest c", foul, 3);
    press = 4'b0001; cyc(2); press = 0; cyc(3);
    chk("R7 sticky", foul, 3);
    chk("R7 alarm sticky", alarm, 1);
  endtask

  task automatic t_allowed();
    host_clear(8'd60); allow = 1;
    press = 4'b1111; cyc(3); press = 0; cyc(1);
    chk("R9 alarm", alarm, 0);
    chk("R9 foul", foul, 0);
  endtask

  initial begin
    cyc(2); rst_n = 1;
    t_reset(); t_load(); t_count(); t_timeout(); t_freeze();
    t_early(); t_multi(); t_allowed();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule